// File: doc/BRIEF.md
# Message Digest Engine Register Front-End

This block is the software-facing control shell of a multi-algorithm message digest engine. A 32-bit register bus lets software soft-reset the engine, program the total message length in bits, choose one of four digest algorithms and an input byte order, manage interrupts, and read the finished digest. The round logic sits outside this block. It sees the configuration on output ports and reports completion through a one-cycle `coreDone` pulse that carries the whole digest.

On completion the digest is stored in a result queue that is popped one word per read. Words come out last word first, so software fills its buffer from the highest index down to zero. Two error flags catch software sequencing mistakes. One is raised when the queue is read while empty. The other is raised when message data is written while the engine is unconfigured. Four sticky status flags are masked by an enable register and combined into one interrupt line. A write-one-to-clear register clears them.

Top module: `hash_frontend`

## Requirements
- R1: After the reset input is released, irq is 0, the status register (0x10) reads 0, and the revision register (0x50) reads the CORE_REV parameter (default 32'h0001_0203).
- R2: Offset 0x4 holds the upper 32 bits and offset 0x8 the lower 32 bits of the 64-bit message length in bits. Both read back, and msgLenBits shows {upper, lower}.
- R3: The control register at 0xC stores the algorithm in bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and the byte order in bits [9:8]. All other bits read as 0. cfgAlgo and cfgOrder show the stored fields.
- R4: A coreDone pulse outside soft reset loads 4, 5, 7 or 8 digest words for algorithms 0 to 3. Word i is taken from coreDigest[32*i+31:32*i]. Status bits 0 (results available) and 1 (new result set) are set.
- R5: Each read of 0x1C pops one word. The first pop returns the highest loaded word index and each following pop returns the next lower index, down to 0.
- R6: A read of 0x1C while the queue is empty returns 0 and sets status bit 2.
- R7: A msgWrite pulse while the engine is unconfigured sets status bit 3. Once the control register has been written, msgWrite has no effect on status.
- R8: Offset 0x14 holds a 4-bit enable mask. irq is 1 exactly when some status bit and its enable bit are both 1.
- R9: Writing 1 to a bit of 0x18 clears that status bit, and writing 0 leaves it unchanged. If a set event and a clear hit the same bit in the same cycle, the bit stays set. 0x18 reads as 0.
- R10: Writing 1 to bit 0 of 0x0 holds the engine in soft reset, and writing 0 releases it. engineRst follows the bit. While it is held, the queue is empty, all status bits are 0, coreDone is ignored and the engine becomes unconfigured.
- R11: Read data appears on busRdData after the clock edge that samples busRdEn. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W (8) | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| msgWrite | input | 1 | Pulse for each message word written on the data port |
| coreDone | input | 1 | One-cycle completion pulse from the hash core |
| coreDigest | input | 32*MAX_WORDS (256) | Digest words, word i in bits [32*i+31:32*i] |
| engineRst | output | 1 | Soft reset held by software |
| cfgAlgo | output | 2 | Selected algorithm |
| cfgOrder | output | 2 | Selected input byte order |
| msgLenBits | output | 64 | Programmed message length in bits |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the rising edge that samples busWrEn, and so does the status and queue update caused by coreDone or msgWrite. Outputs such as cfgAlgo, msgLenBits, engineRst and irq therefore change after that edge, not one cycle later. A read also has one edge of latency: busRdData holds the value captured at the sampling edge, and a queue pop or empty-read error is recorded at that same edge. The bench drives every input on a falling edge and samples on the following falling edge, half a cycle after the result is due. It checks the same-cycle clear and set race by driving both on one falling edge.

// File: rtl/hashfe_pkg.sv
package hashfe_pkg;
  localparam int DATA_W    = 32;
  localparam int STAT_W    = 4;
  localparam int ALGO_W    = 2;
  localparam int ORDER_W   = 2;
  localparam int ORDER_LSB = 8;

  localparam int OFF_RST   = 'h00;
  localparam int OFF_LENHI = 'h04;
  localparam int OFF_LENLO = 'h08;
  localparam int OFF_CTRL  = 'h0C;
  localparam int OFF_STAT  = 'h10;
  localparam int OFF_INTEN = 'h14;
  localparam int OFF_CLR   = 'h18;
  localparam int OFF_QUEUE = 'h1C;
  localparam int OFF_REV   = 'h50;

  typedef enum logic [3:0] {
    RD_ZERO, RD_RST, RD_LENHI, RD_LENLO, RD_CTRL,
    RD_STAT, RD_INTEN, RD_QUEUE, RD_REV
  } rdsel_e;

  typedef struct packed {
    logic wrRst;
    logic wrLenHi;
    logic wrLenLo;
    logic wrCtrl;
    logic wrIntEn;
    logic wrIntClr;
    logic rdStb;
    logic pop;
  } strobe_t;

  function automatic int wordsFor(input logic [ALGO_W-1:0] algo);
    case (algo)
      2'd0:    return 4;
      2'd1:    return 5;
      2'd2:    return 7;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/hashfe_ctrl.sv
module hashfe_ctrl
  import hashfe_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           stb,
  output rdsel_e            rdSel
);
  always_comb begin
    stb = '0;
    stb.rdStb = busRdEn;
    if (busWrEn) begin
      stb.wrRst    = (busAddr == ADDR_W'(OFF_RST));
      stb.wrLenHi  = (busAddr == ADDR_W'(OFF_LENHI));
      stb.wrLenLo  = (busAddr == ADDR_W'(OFF_LENLO));
      stb.wrCtrl   = (busAddr == ADDR_W'(OFF_CTRL));
      stb.wrIntEn  = (busAddr == ADDR_W'(OFF_INTEN));
      stb.wrIntClr = (busAddr == ADDR_W'(OFF_CLR));
    end
    stb.pop = busRdEn && (busAddr == ADDR_W'(OFF_QUEUE));
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(OFF_RST):   rdSel = RD_RST;
      ADDR_W'(OFF_LENHI): rdSel = RD_LENHI;
      ADDR_W'(OFF_LENLO): rdSel = RD_LENLO;
      ADDR_W'(OFF_CTRL):  rdSel = RD_CTRL;
      ADDR_W'(OFF_STAT):  rdSel = RD_STAT;
      ADDR_W'(OFF_INTEN): rdSel = RD_INTEN;
      ADDR_W'(OFF_QUEUE): rdSel = RD_QUEUE;
      ADDR_W'(OFF_REV):   rdSel = RD_REV;
      default:            rdSel = RD_ZERO;
    endcase
  end

  // R11: the address decode never selects two registers at once
  assert_one_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrRst, stb.wrLenHi, stb.wrLenLo, stb.wrCtrl, stb.wrIntEn, stb.wrIntClr}));
endmodule

// File: rtl/hashfe_dp.sv
module hashfe_dp
  import hashfe_pkg::*;
#(
  parameter int          MAX_WORDS = 8,
  parameter logic [31:0] CORE_REV  = 32'h0001_0203
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  rdsel_e                      rdSel,
  input  logic [DATA_W-1:0]           busWrData,
  output logic [DATA_W-1:0]           busRdData,
  input  logic                        msgWrite,
  input  logic                        coreDone,
  input  logic [DATA_W*MAX_WORDS-1:0] coreDigest,
  output logic                        engineRst,
  output logic [ALGO_W-1:0]           cfgAlgo,
  output logic [ORDER_W-1:0]          cfgOrder,
  output logic [2*DATA_W-1:0]         msgLenBits,
  output logic                        irq
);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic              softRst, configured;
  logic [DATA_W-1:0] lenHi, lenLo;
  logic [ALGO_W-1:0] algo;
  logic [ORDER_W-1:0] order;
  logic [STAT_W-1:0] status, statusNxt, intEn;
  logic [CNT_W-1:0]  qCount;
  logic [DATA_W-1:0] qMem [MAX_WORDS];
  logic [IDX_W-1:0]  topIdx;
  logic              loadQ, popEmpty;

  assign loadQ    = coreDone && !softRst;
  assign popEmpty = stb.pop && (qCount == '0) && !softRst;
  assign topIdx   = IDX_W'(qCount - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst <= 1'b0;
      lenHi   <= '0;
      lenLo   <= '0;
      algo    <= '0;
      order   <= '0;
      intEn   <= '0;
    end else begin
      if (stb.wrRst)   softRst <= busWrData[0];
      if (stb.wrLenHi) lenHi   <= busWrData;
      if (stb.wrLenLo) lenLo   <= busWrData;
      if (stb.wrCtrl) begin
        algo  <= busWrData[ALGO_W-1:0];
        order <= busWrData[ORDER_LSB +: ORDER_W];
      end
      if (stb.wrIntEn) intEn <= busWrData[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             configured <= 1'b0;
    else if (softRst)      configured <= 1'b0;
    else if (stb.wrCtrl)   configured <= 1'b1;
  end

  always_comb begin
    statusNxt = status;
    if (stb.wrIntClr) statusNxt = statusNxt & ~busWrData[STAT_W-1:0];
    if (loadQ)        statusNxt[1:0] = 2'b11;
    if (popEmpty)     statusNxt[2] = 1'b1;
    if (msgWrite && !configured) statusNxt[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        status <= '0;
    else if (softRst) status <= '0;
    else              status <= statusNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          qCount <= '0;
    else if (softRst)                   qCount <= '0;
    else if (loadQ)                     qCount <= CNT_W'(wordsFor(algo));
    else if (stb.pop && qCount != '0)   qCount <= qCount - 1'b1;
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (loadQ) qMem[w] <= coreDigest[DATA_W*w +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (stb.rdStb) begin
      case (rdSel)
        RD_RST:   busRdData <= DATA_W'(softRst);
        RD_LENHI: busRdData <= lenHi;
        RD_LENLO: busRdData <= lenLo;
        RD_CTRL: begin
          busRdData <= '0;
          busRdData[ALGO_W-1:0] <= algo;
          busRdData[ORDER_LSB +: ORDER_W] <= order;
        end
        RD_STAT:  busRdData <= DATA_W'(status);
        RD_INTEN: busRdData <= DATA_W'(intEn);
        RD_QUEUE: busRdData <= (qCount != '0) ? qMem[topIdx] : '0;
        RD_REV:   busRdData <= CORE_REV;
        default:  busRdData <= '0;
      endcase
    end
  end

  assign engineRst  = softRst;
  assign cfgAlgo    = algo;
  assign cfgOrder   = order;
  assign msgLenBits = {lenHi, lenLo};
  assign irq        = |(status & intEn);

  assert_load_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !softRst) |=> (qCount == CNT_W'(wordsFor($past(algo)))));
  assert_done_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !softRst) |=> (status[1:0] == 2'b11));
  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && qCount != '0 && !coreDone && !softRst) |=> (qCount == $past(qCount) - 1'b1));
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && qCount == '0 && !coreDone && !softRst) |=> (status[2] && qCount == '0));
  assert_clear_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrIntClr && busWrData[3] && !msgWrite) |=> !status[3]);
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (qCount == '0 && status == '0 && !configured));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(MAX_WORDS));
endmodule

// File: rtl/hash_frontend.sv
module hash_frontend
  import hashfe_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          MAX_WORDS = 8,
  parameter logic [31:0] CORE_REV  = 32'h0001_0203
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  input  logic                    msgWrite,
  input  logic                    coreDone,
  input  logic [32*MAX_WORDS-1:0] coreDigest,
  output logic                    engineRst,
  output logic [1:0]              cfgAlgo,
  output logic [1:0]              cfgOrder,
  output logic [63:0]             msgLenBits,
  output logic                    irq
);
  strobe_t stb;
  rdsel_e  rdSel;

  hashfe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .stb(stb), .rdSel(rdSel)
  );

  hashfe_dp #(.MAX_WORDS(MAX_WORDS), .CORE_REV(CORE_REV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel),
    .busWrData(busWrData), .busRdData(busRdData), .msgWrite(msgWrite),
    .coreDone(coreDone), .coreDigest(coreDigest), .engineRst(engineRst),
    .cfgAlgo(cfgAlgo), .cfgOrder(cfgOrder), .msgLenBits(msgLenBits), .irq(irq)
  );
endmodule

// File: tb/hash_frontend_bench.sv
module hash_frontend_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   busAddr = '0;
  logic         busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic [31:0]  busRdData;
  logic         msgWrite = 1'b0, coreDone = 1'b0;
  logic [255:0] coreDigest = '0;
  logic         engineRst, irq;
  logic [1:0]   cfgAlgo, cfgOrder;
  logic [63:0]  msgLenBits;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  hash_frontend u_hash_frontend (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .msgWrite(msgWrite), .coreDone(coreDone), .coreDigest(coreDigest),
    .engineRst(engineRst), .cfgAlgo(cfgAlgo), .cfgOrder(cfgOrder),
    .msgLenBits(msgLenBits), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  function automatic logic [31:0] wordVal(input int algo, input int i);
    return 32'hA500_0000 | (32'(algo) << 8) | 32'(i);
  endfunction

  task automatic pulseDone(input int algo);
    @(negedge clk);
    for (int i = 0; i < 8; i++) coreDigest[32*i +: 32] = wordVal(algo, i);
    coreDone = 1'b1;
    @(negedge clk);
    coreDone = 1'b0;
  endtask

  task automatic softReset();
    busWrite(8'h00, 32'h1);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 64'(irq), 64'd0);
    busRead(8'h10, d); check("R1 status after reset", 64'(d), 64'd0);
    busRead(8'h50, d); check("R1 revision", 64'(d), 64'h0001_0203);
    busRead(8'h3C, d); check("R11 unmapped read", 64'(d), 64'd0);
  endtask

  task automatic t_length();
    logic [31:0] d;
    busWrite(8'h04, 32'h0000_0001);
    busWrite(8'h08, 32'h8000_0200);
    busRead(8'h04, d); check("R2 length upper", 64'(d), 64'h1);
    busRead(8'h08, d); check("R2 length lower", 64'(d), 64'h8000_0200);
    check("R2 length port", msgLenBits, 64'h0000_0001_8000_0200);
  endtask

  task automatic t_control();
    logic [31:0] d;
    busWrite(8'h0C, 32'hFFFF_FFFE);
    busRead(8'h0C, d); check("R3 control readback", 64'(d), 64'h302);
    check("R3 algo port", 64'(cfgAlgo), 64'd2);
    check("R3 order port", 64'(cfgOrder), 64'd3);
  endtask

  task automatic t_load(input int algo);
    logic [31:0] d;
    int n;
    n = (algo == 0) ? 4 : (algo == 1) ? 5 : (algo == 2) ? 7 : 8;
    busWrite(8'h18, 32'hF);
    busWrite(8'h0C, 32'(algo));
    pulseDone(algo);
    busRead(8'h10, d); check("R4 status after done", 64'(d & 32'h3), 64'h3);
    for (int i = n - 1; i >= 0; i--) begin
      busRead(8'h1C, d); check("R5 pop order", 64'(d), 64'(wordVal(algo, i)));
    end
    busRead(8'h10, d); check("R6 no empty flag yet", 64'(d & 32'h4), 64'h0);
    busRead(8'h1C, d); check("R6 empty pop data", 64'(d), 64'd0);
    busRead(8'h10, d); check("R6 empty pop flag", 64'(d & 32'h4), 64'h4);
  endtask

  task automatic t_irq();
    busWrite(8'h18, 32'hF);
    busWrite(8'h14, 32'h2);
    check("R8 irq idle", 64'(irq), 64'd0);
    busWrite(8'h0C, 32'h3);
    pulseDone(3);
    check("R8 irq on new result", 64'(irq), 64'd1);
    busWrite(8'h18, 32'h1);
    check("R9 clear other bit keeps irq", 64'(irq), 64'd1);
    busWrite(8'h18, 32'h2);
    check("R8 irq after clear", 64'(irq), 64'd0);
    busWrite(8'h14, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    busWrite(8'h18, 32'hF);
    @(negedge clk);
    busAddr = 8'h18; busWrData = 32'h2; busWrEn = 1'b1; coreDone = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; coreDone = 1'b0;
    busRead(8'h10, d); check("R9 set wins over clear", 64'(d & 32'h2), 64'h2);
    busRead(8'h18, d); check("R9 clear reads zero", 64'(d), 64'd0);
  endtask

  task automatic t_msgErr();
    logic [31:0] d;
    softReset();
    @(negedge clk); msgWrite = 1'b1;
    @(negedge clk); msgWrite = 1'b0;
    busRead(8'h10, d); check("R7 write before config", 64'(d & 32'h8), 64'h8);
    busWrite(8'h18, 32'h8);
    busWrite(8'h0C, 32'h1);
    @(negedge clk); msgWrite = 1'b1;
    @(negedge clk); msgWrite = 1'b0;
    busRead(8'h10, d); check("R7 write after config", 64'(d & 32'h8), 64'h0);
  endtask

  task automatic t_softReset();
    logic [31:0] d;
    busWrite(8'h0C, 32'h0);
    pulseDone(0);
    busWrite(8'h00, 32'h1);
    check("R10 engineRst held", 64'(engineRst), 64'd1);
    busRead(8'h10, d); check("R10 status cleared", 64'(d), 64'd0);
    pulseDone(0);
    busRead(8'h10, d); check("R10 done ignored", 64'(d), 64'd0);
    busWrite(8'h00, 32'h0);
    check("R10 engineRst released", 64'(engineRst), 64'd0);
    busRead(8'h1C, d); check("R10 queue emptied", 64'(d), 64'd0);
    busRead(8'h10, d); check("R10 empty flag after release", 64'(d), 64'h4);
    busWrite(8'h18, 32'hF);
    @(negedge clk); msgWrite = 1'b1;
    @(negedge clk); msgWrite = 1'b0;
    busRead(8'h10, d); check("R10 unconfigured after reset", 64'(d & 32'h8), 64'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_length();
    t_control();
    for (int a = 0; a < 4; a++) t_load(a);
    t_irq();
    t_race();
    t_msgErr();
    t_softReset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule